// File: doc/BRIEF.md
# I2C Command/Data Slave Receiver

This block is the two-wire serial front end of a display controller. It samples the clock and data lines on its own system clock and finds START, repeated START and STOP events. It then decodes the address byte, acknowledges its own address and sorts the bytes that follow into command bytes and display-data bytes. Each payload byte is offered to the rest of the controller on a byte-wide valid/ready stream together with a flag that marks it as data or as a command.

The 7-bit address has a fixed upper part, 01111. The two low bits come from two strap pins, so up to four of these devices can share one bus. The first byte after a write address is a control byte. Its continuation bit (bit 7) and its data/command bit (bit 6) set how the next bytes are classified. A read address makes the block return one status byte. A high-speed master code preamble is recognised and reported on a status pin.

The payload stream has no way to push back on the bus, because clock stretching is not used. A byte is held on the stream until `out_ready` is seen high. A payload byte that completes while an earlier byte is still waiting is acknowledged on the bus but dropped. The held byte is left intact.

Top module: `disp_i2c_rx`

## Requirements
- R1: START is a falling SDA while SCL is high and STOP is a rising SDA while SCL is high. Both lines pass through two-flop synchronisers first, and SDA changes while SCL is low are taken as data.
- R2: An address byte whose bits 7:1 equal {01111, dev_strap[1:0]} is acknowledged: `sda_oe` holds SDA low during the 9th SCL pulse. Bit 0 of that byte is R/W, where 0 means write and 1 means read.
- R3: An address byte that does not match gets no acknowledge, and every byte after it up to the next START or STOP produces no output and no acknowledge.
- R4: An address byte of the form 00001xxx is a master code. It is never acknowledged. `hs_active` goes to 1 when its 9th bit is seen high (not acknowledged) and returns to 0 at STOP.
- R5: The first byte after an acknowledged write address is a control byte, with bit 7 = Co and bit 6 = D/C. Control bytes are acknowledged and never appear on the output.
- R6: After a control byte with Co = 0, every later byte up to STOP or repeated START is payload, classified by that control byte's D/C.
- R7: After a control byte with Co = 1, the next byte is payload and the byte after that is a control byte again, so the two kinds alternate.
- R8: Every payload byte is acknowledged and presented on `out_data` with `out_is_data` = D/C (1 = display data, 0 = command). Bytes leave in bus order.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_is_data` stay unchanged. A payload byte that completes during that time is dropped.
- R10: After a matching read address, `status_byte` is sent MSB first. SDA is released for the 9th pulse whether the master acknowledges or not, and the block leaves SDA alone until the next START or STOP.
- R11: `sda_oe` changes only while the synchronised SCL is low, except at START or STOP. STOP releases SDA.
- R12: A repeated START followed by a matching write address restarts parsing, so the next byte is again a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_strap | input | 2 | Low two address bits |
| status_byte | input | 8 | Byte returned on a read |
| hs_active | output | 1 | High-speed preamble seen, cleared by STOP |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Consumer accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
Assertions watch, on every cycle, that the slave never moves its SDA drive while SCL is high outside START and STOP, and that nothing is driven during a master-code acknowledge slot. They also check that a STOP releases SDA and clears `hs_active`, that a stalled output byte stays frozen, and that control bytes never reach the stream. The classification of bytes under the different Co and D/C sequences, address filtering by the strap pins, the status-byte read, repeated-START re-parsing and the dropping of bytes under back-pressure are shown only by the bench scenarios. Those scenarios drive a modelled open-drain bus and compare the stream against an expected queue.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_ACK, LK_RX, LK_TX, LK_TX_ACK, LK_MC_NACK, LK_SKIP
  } link_state_t;

  localparam int BYTE_W = 8;
  localparam logic [4:0] MC_PREFIX = 5'b00001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, cur, prv;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-1:0], raw[g]};
    end
    assign cur[g] = chain[SYNC_STAGES-1];
    assign prv[g] = chain[SYNC_STAGES];
  end

  assign scl_lvl   = cur[0];
  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_link_engine.sv
module i2c_link_engine
  import disp_i2c_pkg::*;
#(
  parameter int ADDR_HI_W = 5,
  parameter int STRAP_W   = 2,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b01111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_lvl,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  status_byte,
  output logic               sda_oe,
  output logic               byte_stb,
  output logic [BYTE_W-1:0]  byte_val,
  output logic               wr_open,
  output logic               hs_active
);
  localparam int ADDR_W = ADDR_HI_W + STRAP_W;

  link_state_t       state;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-2:0] txsh;
  logic              rw_q;
  logic              ack_drv;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] my_addr;

  assign rx_byte = {shreg, sda_lvl};
  assign my_addr = {ADDR_HI, strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LK_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txsh      <= '0;
      rw_q      <= 1'b0;
      ack_drv   <= 1'b0;
      sda_oe    <= 1'b0;
      byte_stb  <= 1'b0;
      byte_val  <= '0;
      wr_open   <= 1'b0;
      hs_active <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      wr_open  <= 1'b0;
      if (stop_det) begin
        state     <= LK_IDLE;
        sda_oe    <= 1'b0;
        ack_drv   <= 1'b0;
        hs_active <= 1'b0;
      end else if (start_det) begin
        state   <= LK_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        ack_drv <= 1'b0;
      end else begin
        case (state)
          LK_ADDR: if (scl_rise) begin
            shreg   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (rx_byte[7:3] == MC_PREFIX) begin
                state <= LK_MC_NACK;
              end else if (rx_byte[7:1] == my_addr) begin
                rw_q    <= rx_byte[0];
                wr_open <= ~rx_byte[0];
                state   <= LK_ACK;
              end else begin
                state <= LK_SKIP;
              end
            end
          end
          LK_MC_NACK: if (scl_rise) begin
            hs_active <= sda_lvl;
            state     <= LK_SKIP;
          end
          LK_ACK: if (scl_fall) begin
            if (!ack_drv) begin
              ack_drv <= 1'b1;
              sda_oe  <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              bit_cnt <= '0;
              if (rw_q) begin
                txsh   <= status_byte[BYTE_W-2:0];
                sda_oe <= ~status_byte[BYTE_W-1];
                state  <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= LK_RX;
              end
            end
          end
          LK_RX: if (scl_rise) begin
            shreg   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              byte_stb <= 1'b1;
              byte_val <= rx_byte;
              state    <= LK_ACK;
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              sda_oe <= ~txsh[BYTE_W-2];
              txsh   <= {txsh[BYTE_W-3:0], 1'b0};
            end
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) state <= LK_TX_ACK;
            end
          end
          LK_TX_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= LK_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: no acknowledge is driven in the master-code slot
  a_r4_no_mc_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_MC_NACK) |-> !sda_oe);

  // R11: drive changes only while SCL is low, outside START/STOP
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start_det || stop_det)) |-> !$past(scl_lvl));

  // R11 / R4: STOP releases SDA and ends high-speed mode
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !hs_active));
endmodule

// File: rtl/i2c_ctrl_parser.sv
module i2c_ctrl_parser
  import disp_i2c_pkg::*;
#(
  parameter int CO_BIT = 7,
  parameter int DC_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_is_data
);
  logic expect_ctrl;
  logic co_q;
  logic dc_q;
  logic slot_free;

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_ctrl <= 1'b1;
      co_q        <= 1'b0;
      dc_q        <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_data <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (wr_open) begin
        expect_ctrl <= 1'b1;
        co_q        <= 1'b0;
      end else if (byte_stb) begin
        if (expect_ctrl) begin
          co_q        <= byte_val[CO_BIT];
          dc_q        <= byte_val[DC_BIT];
          expect_ctrl <= 1'b0;
        end else begin
          expect_ctrl <= co_q;
          if (slot_free) begin
            out_valid   <= 1'b1;
            out_data    <= byte_val;
            out_is_data <= dc_q;
          end
        end
      end
    end
  end

  // R9: a stalled byte stays frozen
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_data)));

  // R5: a control byte never reaches the stream
  a_r5_ctrl_not_emitted: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && expect_ctrl && !out_valid) |=> !out_valid);
endmodule

// File: rtl/disp_i2c_rx.sv
module disp_i2c_rx
  import disp_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] dev_strap,
  input  logic [BYTE_W-1:0]  status_byte,
  output logic               hs_active,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_is_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic byte_stb, wr_open;
  logic [BYTE_W-1:0] byte_val;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_link_engine #(.STRAP_W(STRAP_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .strap(dev_strap), .status_byte(status_byte),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_val(byte_val),
    .wr_open(wr_open), .hs_active(hs_active)
  );

  i2c_ctrl_parser u_parse (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .byte_stb(byte_stb),
    .byte_val(byte_val), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_is_data(out_is_data)
  );
endmodule

// File: tb/disp_i2c_rx_bench.sv
module disp_i2c_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 150000;
  localparam logic [6:0] MY_ADDR = 7'b0111110;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_oe, hs_active, out_valid, out_ready, out_is_data;
  logic [1:0] dev_strap = 2'b10;
  logic [7:0] status_byte = 8'hA5, out_data;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  logic [8:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_i2c_rx u_disp_i2c_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_strap(dev_strap), .status_byte(status_byte), .hs_active(hs_active),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_data(out_is_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); ack = sda_bus; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    put_byte(b, a);
    chk(a == exp_ack, req, a, exp_ack);
  endtask

  // driver: payload byte pushes its expected stream item
  task automatic send_payload(input logic [7:0] b, input logic dc, input string req);
    expq.push_back({dc, b});
    send(b, 1'b0, req);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected byte", {out_is_data, out_data}, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({out_is_data, out_data} == e, "R8 stream item", {out_is_data, out_data}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", cyc, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    out_ready = 1;
    wq(5); rst_n = 1; wq(5);
    chk(!out_valid && !sda_oe && !hs_active, "R1 reset state",
        {out_valid, sda_oe, hs_active}, 0);

    // R2 R5 R6 R8: Co=0, D/C=1 stream of display data
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    send(8'h40, 1'b0, "R5 control ack");
    send_payload(8'h12, 1'b1, "R6 data 1");
    send_payload(8'hF0, 1'b1, "R6 data 2");
    send_payload(8'h00, 1'b1, "R6 data 3");
    bus_stop;

    // R6: Co=0, D/C=0 commands
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    send(8'h00, 1'b0, "R5 control ack");
    send_payload(8'h81, 1'b0, "R6 command 1");
    send_payload(8'h7E, 1'b0, "R6 command 2");
    bus_stop;

    // R7: Co=1 alternation
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R2 address ack");
    send(8'h80, 1'b0, "R7 control Co1 cmd");
    send_payload(8'h30, 1'b0, "R7 cmd after Co1");
    send(8'hC0, 1'b0, "R7 control Co1 data");
    send_payload(8'h44, 1'b1, "R7 data after Co1");
    send(8'h40, 1'b0, "R7 control Co0 data");
    send_payload(8'h55, 1'b1, "R7 stream 1");
    send_payload(8'h66, 1'b1, "R7 stream 2");
    bus_stop;

    // R3: other strap value is ignored
    bus_start;
    send({5'b01111, 2'b01, 1'b0}, 1'b1, "R3 foreign address nack");
    send(8'h40, 1'b1, "R3 no ack after mismatch");
    send(8'h99, 1'b1, "R3 no ack after mismatch");
    chk(!out_valid, "R3 no output", out_valid, 0);
    bus_stop;

    // R4: master code then repeated START
    bus_start;
    send(8'h0B, 1'b1, "R4 master code not acked");
    wq(4);
    chk(hs_active, "R4 hs after nack", hs_active, 1);
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R4 address after Sr");
    send(8'h00, 1'b0, "R5 control ack");
    send_payload(8'h21, 1'b0, "R4 command in hs");
    chk(hs_active, "R4 hs held", hs_active, 1);
    bus_stop;
    chk(!hs_active, "R4 hs cleared by stop", hs_active, 0);

    // R12: repeated START restarts control parsing
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R12 address");
    send(8'h40, 1'b0, "R12 control");
    send_payload(8'h77, 1'b1, "R12 data before Sr");
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R12 address after Sr");
    send(8'h00, 1'b0, "R12 control again");
    send_payload(8'h12, 1'b0, "R12 command after Sr");
    bus_stop;

    // R10: status read, master nack
    bus_start;
    send({MY_ADDR, 1'b1}, 1'b0, "R10 read address ack");
    rd = '0;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1; wq(Q); rd[i] = sda_bus; wq(Q); m_scl = 0; wq(Q);
    end
    chk(rd == 8'hA5, "R10 status byte", rd, 8'hA5);
    wq(Q); m_scl = 1; wq(Q);
    chk(sda_bus == 1'b1, "R10 sda released at ack slot", sda_bus, 1);
    wq(Q); m_scl = 0; wq(Q);
    chk(!sda_oe, "R10 no drive after byte", sda_oe, 0);
    bus_stop;
    chk(!sda_oe, "R11 released after stop", sda_oe, 0);

    // R9: back-pressure
    out_ready = 0;
    bus_start;
    send({MY_ADDR, 1'b0}, 1'b0, "R9 address");
    send(8'h40, 1'b0, "R9 control");
    expq.push_back(9'h111);
    send(8'h11, 1'b0, "R9 first payload acked");
    send(8'h22, 1'b0, "R9 dropped payload acked");
    chk(out_valid && out_data == 8'h11 && out_is_data, "R9 held byte",
        {out_valid, out_is_data, out_data}, 10'h311);
    bus_stop;
    out_ready = 1;
    wq(20);
    chk(expq.size() == 0, "R8 R9 queue drained", expq.size(), 0);
    chk(!out_valid, "R9 second byte dropped", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule